// File: doc/BRIEF.md
# Latched 64-bit Match Timer

This block is a memory-mapped system timer. A prescaler derives a count enable from the input clock. A 64-bit free-running counter advances on that enable. Six 32-bit compare channels watch the low word of the counter. A compare hit sets a sticky status bit, which the block can report as a level interrupt. On the last channel, a compare hit can also issue a one-cycle reset request when the watchdog option is enabled.

Software reads the counter without tearing by issuing a snapshot command. The command copies all 64 bits into a pair of holding registers in a single clock, and software then reads the two words at leisure. Software may also overwrite either counter word directly, and counting resumes from the written value. The bus is a plain 32-bit register port: a write takes effect at the clock edge on which `bus_we_i` is high, and read data is a combinational function of `bus_addr_i`.

Top module: `mtmr_top`

## Requirements
- R1: While reset is asserted, every register reads as zero, `irq_o` is 0 and `wdog_rst_o` is 0. The divider resets to 0.
- R2: The divider register at offset 0x2C holds DIV in its low 16 bits. The counter advances by one every 2*(DIV+1) clock cycles. A write to the divider or to either counter word restarts this interval, so the first increment lands 2*(DIV+1) cycles after the write edge.
- R3: Offset 0x00 reads and writes the low counter word and offset 0x04 the high counter word. Counting continues from the written value.
- R4: A write of 1 in bit 0 at offset 0x30 copies the full 64-bit counter value held just before that edge into offsets 0x34 (low) and 0x38 (high) at once. A write there with bit 0 clear leaves both snapshot words unchanged.
- R5: Channel n (n = 0..5) compares its register at offset 0x08+4n with the low counter word. Status bit n at offset 0x20 is set on the increment that makes the low word equal to the compare value, including a wrap to zero. It is not set again while the value merely stays equal.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: `irq_o` is high while any status bit n is set together with enable bit n at offset 0x24, and it stays high until that status bit is cleared. A set status bit with its enable clear does not raise `irq_o`.
- R8: When bit 0 of offset 0x28 is set, a channel 5 hit drives `wdog_rst_o` high for exactly one cycle, in the same cycle that status bit 5 becomes set. With that bit clear, no pulse occurs, but status bit 5 is still set.
- R9: Reads of offset 0x30 and of any offset not listed here return zero.
- R10: The counter is 64 bits wide: an increment from a low word of all ones carries into the high word.
- R11: A direct write to the counter takes priority over a pending increment and never sets a status bit, even when the written low word equals a compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Byte offset of the register, word aligned |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| irq_o | output | 1 | Level interrupt: any enabled status bit set |
| wdog_rst_o | output | 1 | One-cycle watchdog reset request |

## Verification
The assertions assume that the prescaler interval is at least two cycles. They also assume that the bus is the only path that changes the counter, the snapshot and the interrupt sources. The sticky-interrupt property exempts exactly the cycles in which the status or enable register is written. The stimulus drives one bus operation per cycle, away from the clock edge. Before moving a compare register or the counter near a compare value, it freezes counting with the largest divider, so that no hit lands during setup.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  localparam int OFF_CNT_LO  = 'h00;
  localparam int OFF_CNT_HI  = 'h04;
  localparam int OFF_MATCH0  = 'h08;
  localparam int OFF_STATUS  = 'h20;
  localparam int OFF_IEN     = 'h24;
  localparam int OFF_WDEN    = 'h28;
  localparam int OFF_DIV     = 'h2C;
  localparam int OFF_LATCH   = 'h30;
  localparam int OFF_LAT_LO  = 'h34;
  localparam int OFF_LAT_HI  = 'h38;

  function automatic int match_off(input int idx);
    return OFF_MATCH0 + 4 * idx;
  endfunction
endpackage

// File: rtl/mtmr_rstsync.sv
module mtmr_rstsync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/mtmr_presc.sv
module mtmr_presc #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);
  localparam int PC_W = DIV_W + 1;

  logic [PC_W-1:0] pcnt_q, pcnt_d;
  logic [PC_W-1:0] limit;
  logic            at_limit;

  // one tick every 2*(div+1) cycles: count 0 .. 2*div+1
  assign limit    = {div_i, 1'b1};
  assign at_limit = (pcnt_q == limit);
  assign tick_o   = at_limit & ~restart_i;

  always_comb begin
    pcnt_d = pcnt_q + PC_W'(1);
    if (restart_i || at_limit) pcnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pcnt_q <= '0;
    else         pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/mtmr_count.sv
module mtmr_count #(
  parameter int WORD_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [2*WORD_W-1:0] cnt_o
);
  localparam int CNT_W = 2 * WORD_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = tick_i | wr_lo_i | wr_hi_i;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) cnt_d[WORD_W-1:0]     = wdata_i;
      if (wr_hi_i) cnt_d[CNT_W-1:WORD_W] = wdata_i;
    end else if (tick_i) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/mtmr_match.sv
module mtmr_match #(
  parameter int NCH    = 6,
  parameter int WORD_W = 32
) (
  input  logic                         tick_i,
  input  logic [WORD_W-1:0]            cnt_lo_i,
  input  logic [NCH-1:0][WORD_W-1:0]   cmp_i,
  output logic [NCH-1:0]               hit_o
);
  logic [WORD_W-1:0] lo_next;

  // compare against the value the low word takes at this tick
  assign lo_next = cnt_lo_i + WORD_W'(1);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign hit_o[n] = tick_i & (lo_next == cmp_i[n]);
  end
endmodule

// File: rtl/mtmr_top.sv
module mtmr_top #(
  parameter int ADDR_W = 8,
  parameter int NCH    = 6,
  parameter int DIV_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  output logic              wdog_rst_o
);
  import mtmr_pkg::*;

  localparam int WORD_W  = 32;
  localparam int CNT_W   = 2 * WORD_W;
  localparam int WDOG_CH = NCH - 1;

  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(OFF_CNT_LO);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(OFF_CNT_HI);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_IEN    = ADDR_W'(OFF_IEN);
  localparam logic [ADDR_W-1:0] A_WDEN   = ADDR_W'(OFF_WDEN);
  localparam logic [ADDR_W-1:0] A_DIV    = ADDR_W'(OFF_DIV);
  localparam logic [ADDR_W-1:0] A_LATCH  = ADDR_W'(OFF_LATCH);
  localparam logic [ADDR_W-1:0] A_LAT_LO = ADDR_W'(OFF_LAT_LO);
  localparam logic [ADDR_W-1:0] A_LAT_HI = ADDR_W'(OFF_LAT_HI);

  logic rst_n;

  logic wr_cnt_lo, wr_cnt_hi, wr_status, wr_ien, wr_wden, wr_div, wr_latch;
  logic [NCH-1:0] wr_match;

  logic [NCH-1:0][WORD_W-1:0] match_q, match_d;
  logic [NCH-1:0]             status_q, status_d;
  logic [NCH-1:0]             ien_q, ien_d;
  logic                       wden_q, wden_d;
  logic [DIV_W-1:0]           div_q, div_d;
  logic [CNT_W-1:0]           lat_q, lat_d;
  logic                       wdog_q, wdog_d;

  logic [CNT_W-1:0] cnt_q;
  logic             tick;
  logic             presc_restart;
  logic [NCH-1:0]   hit;
  logic [NCH-1:0]   clr_mask;

  mtmr_rstsync u_rstsync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  // write decode
  always_comb begin
    wr_cnt_lo = bus_we_i && (bus_addr_i == A_CNT_LO);
    wr_cnt_hi = bus_we_i && (bus_addr_i == A_CNT_HI);
    wr_status = bus_we_i && (bus_addr_i == A_STATUS);
    wr_ien    = bus_we_i && (bus_addr_i == A_IEN);
    wr_wden   = bus_we_i && (bus_addr_i == A_WDEN);
    wr_div    = bus_we_i && (bus_addr_i == A_DIV);
    wr_latch  = bus_we_i && (bus_addr_i == A_LATCH);
    for (int n = 0; n < NCH; n++) begin
      wr_match[n] = bus_we_i && (bus_addr_i == ADDR_W'(match_off(n)));
    end
  end

  assign presc_restart = wr_div | wr_cnt_lo | wr_cnt_hi;

  mtmr_presc #(.DIV_W(DIV_W)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .div_i     (div_q),
    .restart_i (presc_restart),
    .tick_o    (tick)
  );

  mtmr_count #(.WORD_W(WORD_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .tick_i  (tick),
    .wr_lo_i (wr_cnt_lo),
    .wr_hi_i (wr_cnt_hi),
    .wdata_i (bus_wdata_i),
    .cnt_o   (cnt_q)
  );

  mtmr_match #(.NCH(NCH), .WORD_W(WORD_W)) u_match (
    .tick_i   (tick),
    .cnt_lo_i (cnt_q[WORD_W-1:0]),
    .cmp_i    (match_q),
    .hit_o    (hit)
  );

  // next-state for the register file
  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      match_d[n] = wr_match[n] ? bus_wdata_i : match_q[n];
    end
    clr_mask = wr_status ? bus_wdata_i[NCH-1:0] : '0;
    status_d = (status_q & ~clr_mask) | hit;
    ien_d    = wr_ien  ? bus_wdata_i[NCH-1:0] : ien_q;
    wden_d   = wr_wden ? bus_wdata_i[0]       : wden_q;
    div_d    = wr_div  ? bus_wdata_i[DIV_W-1:0] : div_q;
    lat_d    = (wr_latch && bus_wdata_i[0]) ? cnt_q : lat_q;
    wdog_d   = hit[WDOG_CH] & wden_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      match_q  <= '0;
      status_q <= '0;
      ien_q    <= '0;
      wden_q   <= 1'b0;
      div_q    <= '0;
      lat_q    <= '0;
      wdog_q   <= 1'b0;
    end else begin
      match_q  <= match_d;
      status_q <= status_d;
      ien_q    <= ien_d;
      wden_q   <= wden_d;
      div_q    <= div_d;
      lat_q    <= lat_d;
      wdog_q   <= wdog_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_CNT_LO: bus_rdata_o = cnt_q[WORD_W-1:0];
      A_CNT_HI: bus_rdata_o = cnt_q[CNT_W-1:WORD_W];
      A_STATUS: bus_rdata_o[NCH-1:0] = status_q;
      A_IEN:    bus_rdata_o[NCH-1:0] = ien_q;
      A_WDEN:   bus_rdata_o[0] = wden_q;
      A_DIV:    bus_rdata_o[DIV_W-1:0] = div_q;
      A_LAT_LO: bus_rdata_o = lat_q[WORD_W-1:0];
      A_LAT_HI: bus_rdata_o = lat_q[CNT_W-1:WORD_W];
      default: begin
        for (int n = 0; n < NCH; n++) begin
          if (bus_addr_i == ADDR_W'(match_off(n))) bus_rdata_o = match_q[n];
        end
      end
    endcase
  end

  assign irq_o      = |(status_q & ien_q);
  assign wdog_rst_o = wdog_q;
endmodule

// File: rtl/mtmr_chk.sv
module mtmr_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic              latch_bit,
  input logic [63:0]       cnt,
  input logic [63:0]       lat,
  input logic              tick,
  input logic              wden,
  input logic              irq,
  input logic              wdog
);
  import mtmr_pkg::*;

  logic cnt_wr, latch_cmd, irq_src_wr;

  assign cnt_wr     = we && (addr == ADDR_W'(OFF_CNT_LO) || addr == ADDR_W'(OFF_CNT_HI));
  assign latch_cmd  = we && (addr == ADDR_W'(OFF_LATCH)) && latch_bit;
  assign irq_src_wr = we && (addr == ADDR_W'(OFF_STATUS) || addr == ADDR_W'(OFF_IEN));

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick); // R2
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 64'd1)); // R10
  AST_LATCH_SNAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_cmd |=> lat == $past(cnt)); // R4
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_cmd |=> $stable(lat)); // R4
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq && !irq_src_wr) |=> irq); // R7
  AST_WDOG_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog |=> !wdog); // R8
  AST_WDOG_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog |-> $past(wden)); // R8
endmodule

bind mtmr_top mtmr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we        (bus_we_i),
  .addr      (bus_addr_i),
  .latch_bit (bus_wdata_i[0]),
  .cnt       (cnt_q),
  .lat       (lat_q),
  .tick      (tick),
  .wden      (wden_q),
  .irq       (irq_o),
  .wdog      (wdog_rst_o)
);

// File: tb/mtmr_top_tb.sv
module mtmr_top_tb;
  typedef struct {
    int          kind;   // 0 read data, 1 irq, 2 watchdog
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        we;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq, wdog;
  logic        mon_req;

  item_t sb_q[$];
  int    n_checks = 0;
  int    n_errors = 0;

  always #5 clk = ~clk;

  mtmr_top u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq),
    .wdog_rst_o  (wdog)
  );

  // monitor: compares at the falling edge
  always @(negedge clk) begin
    if (mon_req && sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        1:       act = {31'd0, irq};
        2:       act = {31'd0, wdog};
        default: act = rdata;
      endcase
      n_checks++;
      if (act !== it.exp) begin
        n_errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    #1; we = 1'b1; addr = a; wdata = d; mon_req = 1'b0;
    @(posedge clk);
  endtask

  task automatic push_chk(input int k, input logic [7:0] a, input logic [31:0] e, input string t);
    item_t it;
    #1; we = 1'b0; addr = a; wdata = '0; mon_req = 1'b1;
    it.kind = k; it.exp = e; it.tag = t;
    sb_q.push_back(it);
    @(posedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    push_chk(0, a, e, t);
  endtask

  task automatic idle(input int n);
    #1; we = 1'b0; mon_req = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; we = 1'b0; addr = '0; wdata = '0; mon_req = 1'b0;
    repeat (2) @(posedge clk);
    // R1 reset state
    rd(8'h00, 32'h0, "R1 cnt_lo");
    rd(8'h20, 32'h0, "R1 status");
    rd(8'h2C, 32'h0, "R1 div");
    rd(8'h34, 32'h0, "R1 lat_lo");
    push_chk(1, 8'h00, 32'h0, "R1 irq");
    push_chk(2, 8'h00, 32'h0, "R1 wdog");
    #1; rst_ni = 1'b1; mon_req = 1'b0;
    @(posedge clk);
    idle(3);

    // R3 / R4 / R9 with counting frozen
    wr(8'h2C, 32'h0000_FFFF);
    wr(8'h04, 32'h0000_1234);
    wr(8'h00, 32'hFFFF_FFF0);
    rd(8'h00, 32'hFFFF_FFF0, "R3 cnt_lo");
    rd(8'h04, 32'h0000_1234, "R3 cnt_hi");
    rd(8'h2C, 32'h0000_FFFF, "R2 div readback");
    wr(8'h30, 32'h1);
    rd(8'h34, 32'hFFFF_FFF0, "R4 lat_lo");
    rd(8'h38, 32'h0000_1234, "R4 lat_hi");
    wr(8'h00, 32'h5);
    wr(8'h30, 32'h0);
    rd(8'h34, 32'hFFFF_FFF0, "R4 no-snap");
    rd(8'h30, 32'h0, "R9 latch cmd");
    rd(8'h3C, 32'h0, "R9 hole");
    rd(8'hFC, 32'h0, "R9 top");

    // R2 period with DIV=2 (six cycles)
    wr(8'h2C, 32'h2);
    wr(8'h04, 32'h0);
    wr(8'h00, 32'h0);
    idle(5);
    rd(8'h00, 32'h0, "R2 before step");
    rd(8'h00, 32'h1, "R2 at step");

    // R10 carry, DIV=0 (two cycles)
    wr(8'h2C, 32'h0);
    wr(8'h04, 32'h7);
    wr(8'h00, 32'hFFFF_FFFF);
    idle(3);
    wr(8'h30, 32'h1);
    rd(8'h34, 32'h0, "R10 lat_lo");
    rd(8'h38, 32'h8, "R10 lat_hi");
    rd(8'h20, 32'h3F, "R5 wrap to zero hits");

    // R5 / R6 / R7
    wr(8'h2C, 32'h0000_FFFF);
    wr(8'h20, 32'h3F);
    rd(8'h20, 32'h0, "R6 clear all");
    wr(8'h24, 32'h1);
    wr(8'h08, 32'd10);
    wr(8'h2C, 32'h2);
    wr(8'h04, 32'h0);
    wr(8'h00, 32'd8);
    idle(11);
    rd(8'h20, 32'h0, "R5 before hit");
    rd(8'h20, 32'h1, "R5 hit");
    push_chk(1, 8'h00, 32'h1, "R7 irq set");
    wr(8'h20, 32'h0);
    rd(8'h20, 32'h1, "R6 write zero");
    wr(8'h20, 32'h1);
    rd(8'h20, 32'h0, "R5 no re-set while equal");
    push_chk(1, 8'h00, 32'h0, "R7 irq cleared");

    // R11 direct write equal to compare
    wr(8'h2C, 32'h0000_FFFF);
    wr(8'h0C, 32'h50);
    wr(8'h00, 32'h50);
    rd(8'h20, 32'h0, "R11 write no hit");
    rd(8'h0C, 32'h50, "R5 match1 readback");

    // R8 watchdog enabled
    wr(8'h24, 32'h0);
    wr(8'h1C, 32'd20);
    wr(8'h28, 32'h1);
    rd(8'h28, 32'h1, "R8 wden readback");
    wr(8'h2C, 32'h0);
    wr(8'h04, 32'h0);
    wr(8'h00, 32'd18);
    idle(3);
    push_chk(2, 8'h00, 32'h0, "R8 before hit");
    push_chk(2, 8'h00, 32'h1, "R8 pulse");
    push_chk(2, 8'h00, 32'h0, "R8 one cycle");
    push_chk(1, 8'h00, 32'h0, "R7 gated irq");
    rd(8'h20, 32'h20, "R8 status5");

    // R8 watchdog disabled
    wr(8'h2C, 32'h0000_FFFF);
    wr(8'h20, 32'h20);
    wr(8'h28, 32'h0);
    wr(8'h2C, 32'h0);
    wr(8'h00, 32'd18);
    idle(3);
    push_chk(2, 8'h00, 32'h0, "R8 disabled a");
    push_chk(2, 8'h00, 32'h0, "R8 disabled b");
    rd(8'h20, 32'h20, "R8 status without pulse");

    idle(2);
    if (sb_q.size() != 0) begin
      n_checks++; n_errors++;
      $display("FAIL scoreboard: actual=%0d expected=0 pending", sb_q.size());
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule